// File: doc/BRIEF.md
# Random Source Command and Status Front End

This block sits between a host register bus and an abstract entropy source. The host steers it through a fixed protocol by writing 32-bit command words to a single control register, and it follows progress by polling an 8-bit status code. The block moves through the phases in order: clearing, reset acknowledged, released, enabled, self-test, test result, armed and word ready. It starts the entropy source's startup self-test when the host asks for it. It also gates each 32-bit random word so that the host sees the word once and only after the handshake.

The block has no buffering. It holds at most one word. That word reads as zero in every phase except word-ready, and both a reset command and a read acknowledge clear it. The noise source, the conditioning and the statistical tests are outside the block. Only their start/done/pass and word-valid handshakes reach it.

Top module: `trng_host_ctrl`

## Requirements
- R1: After the asynchronous reset, the status read at offset 0x4 is 0x00000000, the random read at offset 0x0 is 0, and ent_req_o and test_start_o are low.
- R2: A write of 0x00000001 to offset 0x0 is accepted in any phase. It zeroes the held word on the next clock. Status then reads 0x00 for exactly CLR_CYCLES cycles and reads 0xAC from then on.
- R3: In status 0xAC, the writes 0x00000002 (release), 0x80000000 (enable) and 0x80000004 (zeroize), in that order, start the self-test. test_start_o is high for exactly one cycle, and status reads 0x00 while the test runs.
- R4: While the test runs, test_done_i with test_pass_i high gives status 0x57, and with test_pass_i low gives 0xFA. If no done arrives within TEST_TIMEOUT cycles of the zeroize write, status becomes 0xFA.
- R5: In status 0x57, a write of 0x80000008 (acknowledge zeroize) raises ent_req_o. Status 0xFA is left only by a reset command: other commands and test_done_i pulses do not change it, and ent_req_o stays low.
- R6: While ent_req_o is high, an ent_valid_i pulse latches ent_word_i. Status then reads 0xED, offset 0x0 returns that word and ent_req_o drops. Later ent_valid_i pulses do not change the word.
- R7: In status 0xED, a write of 0x8000000F (read acknowledge) moves status away from 0xED on the next clock and zeroes the word. A following enable (0x80000000) raises ent_req_o again. ent_valid_i pulses between the two writes are ignored.
- R8: Unrecognised command words, commands that arrive out of sequence, and any write to an offset other than 0x0 leave the phase unchanged.
- R9: Reads at offset 0x4 return the status code in bits 7:0 with bits 31:8 zero. Reads at any offset other than 0x0 and 0x4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | 32 | Write data (command word) |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| test_start_o | output | 1 | One-cycle pulse that starts the startup self-test |
| test_done_i | input | 1 | Self-test finished |
| test_pass_i | input | 1 | Self-test result, valid with test_done_i |
| ent_req_o | output | 1 | Block is waiting for a fresh random word |
| ent_valid_i | input | 1 | ent_word_i carries a fresh word |
| ent_word_i | input | 32 | Random word from the entropy source |

## Verification
A wrong phase shows up as a wrong status code at offset 0x4 on the cycle after the command edge, because the code is decoded straight from the state register. A faulty word path shows up at offset 0x0 within one cycle of a load, an acknowledge or a reset. The clearing delay and the self-test timeout are measured against their exact boundary cycles. These checks catch a counter that is off by one. The out-of-sequence and wrong-offset writes are each followed by a status read, so that a phase that moved when it should have held is detected at once.

// File: rtl/trng_host_pkg.sv
package trng_host_pkg;
  localparam int WORD_W = 32;

  localparam logic [WORD_W-1:0] CW_RESET   = 32'h0000_0001;
  localparam logic [WORD_W-1:0] CW_RELEASE = 32'h0000_0002;
  localparam logic [WORD_W-1:0] CW_ENABLE  = 32'h8000_0000;
  localparam logic [WORD_W-1:0] CW_ZEROIZE = 32'h8000_0004;
  localparam logic [WORD_W-1:0] CW_ACK_ZER = 32'h8000_0008;
  localparam logic [WORD_W-1:0] CW_RD_ACK  = 32'h8000_000F;

  localparam logic [7:0] SC_NONE     = 8'h00;
  localparam logic [7:0] SC_RST_ACK  = 8'hAC;
  localparam logic [7:0] SC_TEST_OK  = 8'h57;
  localparam logic [7:0] SC_TEST_BAD = 8'hFA;
  localparam logic [7:0] SC_WORD_RDY = 8'hED;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_RST, CMD_REL, CMD_EN, CMD_ZER, CMD_ACKZ, CMD_RDACK
  } cmd_e;

  typedef enum logic [3:0] {
    ST_POR, ST_CLEAR, ST_RST_ACK, ST_RELEASED, ST_ENABLED, ST_TESTING,
    ST_PASS, ST_FAIL, ST_ARMED, ST_READY, ST_ACKED
  } state_e;

  function automatic logic [7:0] status_code(state_e s);
    case (s)
      ST_RST_ACK: return SC_RST_ACK;
      ST_PASS:    return SC_TEST_OK;
      ST_FAIL:    return SC_TEST_BAD;
      ST_READY:   return SC_WORD_RDY;
      default:    return SC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/trng_cmd_decode.sv
module trng_cmd_decode
  import trng_host_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output cmd_e              cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_en_i && wr_addr_i == ADDR_W'(CTRL_OFS)) begin
      case (wr_data_i)
        CW_RESET:   cmd_o = CMD_RST;
        CW_RELEASE: cmd_o = CMD_REL;
        CW_ENABLE:  cmd_o = CMD_EN;
        CW_ZEROIZE: cmd_o = CMD_ZER;
        CW_ACK_ZER: cmd_o = CMD_ACKZ;
        CW_RD_ACK:  cmd_o = CMD_RDACK;
        default:    cmd_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/trng_seq_fsm.sv
module trng_seq_fsm
  import trng_host_pkg::*;
#(
  parameter int CLR_CYCLES   = 8,
  parameter int TEST_TIMEOUT = 256
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cmd_e   cmd_i,
  input  logic   test_done_i,
  input  logic   test_pass_i,
  input  logic   ent_valid_i,
  output state_e state_o,
  output logic   test_start_o,
  output logic   ent_req_o,
  output logic   load_o,
  output logic   clear_o
);
  localparam int CNT_MAX = (CLR_CYCLES > TEST_TIMEOUT) ? CLR_CYCLES : TEST_TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(CLR_CYCLES - 1);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TEST_TIMEOUT - 1);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    if (cmd_i == CMD_RST) begin
      state_d = ST_CLEAR;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_CLEAR: begin
          if (cnt_q == CLR_LAST) state_d = ST_RST_ACK;
          else cnt_d = cnt_q + 1'b1;
        end
        ST_RST_ACK:  if (cmd_i == CMD_REL) state_d = ST_RELEASED;
        ST_RELEASED: if (cmd_i == CMD_EN) state_d = ST_ENABLED;
        ST_ENABLED: begin
          if (cmd_i == CMD_ZER) begin
            state_d = ST_TESTING;
            cnt_d   = '0;
            start_d = 1'b1;
          end
        end
        ST_TESTING: begin
          if (test_done_i) state_d = test_pass_i ? ST_PASS : ST_FAIL;
          else if (cnt_q == TO_LAST) state_d = ST_FAIL;
          else cnt_d = cnt_q + 1'b1;
        end
        ST_PASS:  if (cmd_i == CMD_ACKZ) state_d = ST_ARMED;
        ST_ARMED: if (ent_valid_i) state_d = ST_READY;
        ST_READY: if (cmd_i == CMD_RDACK) state_d = ST_ACKED;
        ST_ACKED: if (cmd_i == CMD_EN) state_d = ST_ARMED;
        default:  state_d = state_q;  // POR and FAIL wait for reset
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_POR;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign state_o      = state_q;
  assign test_start_o = start_q;
  assign ent_req_o    = (state_q == ST_ARMED);
  assign load_o       = (state_q == ST_ARMED) && ent_valid_i && (cmd_i != CMD_RST);
  assign clear_o      = (cmd_i == CMD_RST) || ((state_q == ST_READY) && (cmd_i == CMD_RDACK));
endmodule

// File: rtl/trng_word_latch.sv
module trng_word_latch
  import trng_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (clear_i) word_o <= '0;  // zeroize wins over load
    else if (load_i)  word_o <= word_i;
  end
endmodule

// File: rtl/trng_reg_read.sv
module trng_reg_read
  import trng_host_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int RAND_OFS   = 0,
  parameter int STATUS_OFS = 4
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        status_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] rd_data_o
);
  always_comb begin
    if (rd_addr_i == ADDR_W'(RAND_OFS))        rd_data_o = word_i;
    else if (rd_addr_i == ADDR_W'(STATUS_OFS)) rd_data_o = {{(WORD_W-8){1'b0}}, status_i};
    else                                       rd_data_o = '0;
  end
endmodule

// File: rtl/trng_host_ctrl.sv
module trng_host_ctrl
  import trng_host_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int CTRL_OFS     = 0,
  parameter int STATUS_OFS   = 4,
  parameter int CLR_CYCLES   = 8,
  parameter int TEST_TIMEOUT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              test_start_o,
  input  logic              test_done_i,
  input  logic              test_pass_i,
  output logic              ent_req_o,
  input  logic              ent_valid_i,
  input  logic [31:0]       ent_word_i
);
  cmd_e              cmd;
  state_e            state;
  logic              load, clear;
  logic [WORD_W-1:0] word_q;
  logic [7:0]        status_code_w;

  trng_cmd_decode #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_dec (
    .wr_en_i, .wr_addr_i, .wr_data_i, .cmd_o(cmd)
  );

  trng_seq_fsm #(.CLR_CYCLES(CLR_CYCLES), .TEST_TIMEOUT(TEST_TIMEOUT)) u_fsm (
    .clk_i, .rst_ni, .cmd_i(cmd), .test_done_i, .test_pass_i, .ent_valid_i,
    .state_o(state), .test_start_o, .ent_req_o, .load_o(load), .clear_o(clear)
  );

  trng_word_latch u_word (
    .clk_i, .rst_ni, .clear_i(clear), .load_i(load), .word_i(ent_word_i), .word_o(word_q)
  );

  assign status_code_w = status_code(state);

  trng_reg_read #(.ADDR_W(ADDR_W), .RAND_OFS(CTRL_OFS), .STATUS_OFS(STATUS_OFS)) u_rd (
    .rd_addr_i, .status_i(status_code_w), .word_i(word_q), .rd_data_o
  );
endmodule

// File: rtl/trng_host_ctrl_chk.sv
module trng_host_ctrl_chk
  import trng_host_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [31:0]       wr_data_i,
  input logic              test_start_o,
  input logic              ent_req_o,
  input logic [7:0]        status_code_w,
  input logic [31:0]       word_q
);
  logic rst_cmd, rdack_cmd;
  assign rst_cmd   = wr_en_i && wr_addr_i == ADDR_W'(CTRL_OFS) && wr_data_i == CW_RESET;
  assign rdack_cmd = wr_en_i && wr_addr_i == ADDR_W'(CTRL_OFS) && wr_data_i == CW_RD_ACK;

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_start_o |=> !test_start_o); // R3
  AST_RST_ZEROIZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd |=> (word_q == '0 && status_code_w == SC_NONE)); // R2
  AST_READY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_code_w == SC_WORD_RDY) |-> !ent_req_o); // R6
  AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_code_w == SC_WORD_RDY && !rst_cmd && !rdack_cmd) |=>
      (status_code_w == SC_WORD_RDY && $stable(word_q))); // R6
  AST_ACK_LEAVES_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_code_w == SC_WORD_RDY && rdack_cmd) |=>
      (status_code_w != SC_WORD_RDY && word_q == '0)); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_code_w == SC_TEST_BAD && !rst_cmd) |=>
      (status_code_w == SC_TEST_BAD && !ent_req_o)); // R5
endmodule

bind trng_host_ctrl trng_host_ctrl_chk #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .test_start_o, .ent_req_o,
  .status_code_w, .word_q
);

// File: tb/trng_host_ctrl_tb.sv
`timescale 1ns/1ps
module trng_host_ctrl_tb;
  localparam int CLR = 8;
  localparam int TMO = 256;
  localparam logic [3:0] A_CTL = 4'h0, A_ST = 4'h4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0, rd_data_o, ent_word_i = '0;
  logic test_start_o, test_done_i = 1'b0, test_pass_i = 1'b0;
  logic ent_req_o, ent_valid_i = 1'b0;

  always #2.5 clk_i = ~clk_i;

  trng_host_ctrl u_dut (.*);

  typedef struct { int kind; logic [3:0] addr; logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_err = 0, pulse_cnt = 0;
  bit done = 1'b0;

  always @(posedge clk_i) if (rst_ni && test_start_o) pulse_cnt <= pulse_cnt + 1;

  // monitor: compares queued expectations against outputs
  initial forever begin
    wait (sb_q.size() > 0);
    #1;
    begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = rd_data_o;
        1: act = {31'b0, ent_req_o};
        default: act = pulse_cnt;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [3:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    rd_addr_i = addr;
    sb_q.push_back('{kind, addr, exp, tag});
  endtask

  task automatic wr(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic result(input logic pass);
    @(negedge clk_i); test_done_i = 1'b1; test_pass_i = pass;
    @(negedge clk_i); test_done_i = 1'b0;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk_i); ent_valid_i = 1'b1; ent_word_i = w;
    @(negedge clk_i); ent_valid_i = 1'b0;
  endtask

  task automatic startup;
    wr(A_CTL, 32'h1); step(CLR + 1);
    wr(A_CTL, 32'h2); wr(A_CTL, 32'h8000_0000); wr(A_CTL, 32'h8000_0004);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3); rst_ni = 1'b1;
    // R1 reset state
    chk(0, A_ST, 32'h0, "R1 status");
    chk(0, A_CTL, 32'h0, "R1 word");
    chk(1, 0, 32'h0, "R1 ent_req");
    chk(2, 0, 32'd0, "R1 no start pulse");
    // R2 clearing delay boundary
    wr(A_CTL, 32'h1);
    chk(0, A_ST, 32'h0, "R2 clearing");
    step(5);
    chk(0, A_ST, 32'h0, "R2 last clear cycle");
    chk(0, A_ST, 32'hAC, "R2 ack");
    // R8 ignored writes
    wr(A_CTL, 32'h8000_0000);
    chk(0, A_ST, 32'hAC, "R8 out of sequence enable");
    wr(A_CTL, 32'h1234_5678);
    chk(0, A_ST, 32'hAC, "R8 unknown word");
    wr(A_ST, 32'h1);
    step(CLR);
    chk(0, A_ST, 32'hAC, "R8 reset at status offset");
    // R9 address map
    chk(0, 4'h8, 32'h0, "R9 unmapped offset");
    // R3 startup
    wr(A_CTL, 32'h2); wr(A_CTL, 32'h8000_0000); wr(A_CTL, 32'h8000_0004);
    chk(0, A_ST, 32'h0, "R3 testing status");
    step(3);
    chk(2, 0, 32'd1, "R3 single start pulse");
    result(1'b1);
    chk(0, A_ST, 32'h57, "R4 pass");
    wr(A_CTL, 32'h8000_000F);
    chk(0, A_ST, 32'h57, "R8 rdack in pass");
    chk(1, 0, 32'h0, "R8 no req before ackz");
    wr(A_CTL, 32'h8000_0008);
    chk(1, 0, 32'h1, "R5 req after ackz");
    chk(0, A_CTL, 32'h0, "R5 word empty");
    // R6 delivery
    send(32'hA5A5_1234);
    chk(0, A_ST, 32'hED, "R6 ready");
    chk(0, A_CTL, 32'hA5A5_1234, "R6 word");
    chk(1, 0, 32'h0, "R6 req dropped");
    send(32'h0BAD_0BAD);
    chk(0, A_CTL, 32'hA5A5_1234, "R6 word held");
    // R7 ack and re-enable
    wr(A_CTL, 32'h8000_000F);
    chk(0, A_ST, 32'h0, "R7 left ready");
    chk(0, A_CTL, 32'h0, "R7 word cleared");
    send(32'hDEAD_BEEF);
    chk(0, A_ST, 32'h0, "R7 word ignored before enable");
    wr(A_CTL, 32'h8000_0000);
    chk(1, 0, 32'h1, "R7 req again");
    send(32'h1357_9BDF);
    chk(0, A_CTL, 32'h1357_9BDF, "R7 next word");
    // R2 reset from ready
    wr(A_CTL, 32'h1);
    chk(0, A_CTL, 32'h0, "R2 zeroized");
    chk(0, A_ST, 32'h0, "R2 clearing from ready");
    // R4 fail, R5 sticky
    startup();
    result(1'b0);
    chk(0, A_ST, 32'hFA, "R4 fail");
    wr(A_CTL, 32'h8000_0008);
    result(1'b1);
    chk(0, A_ST, 32'hFA, "R5 fail sticky");
    chk(1, 0, 32'h0, "R5 no req in fail");
    // R4 timeout boundary
    startup();
    step(TMO - 2);
    chk(0, A_ST, 32'h0, "R4 before timeout");
    chk(0, A_ST, 32'hFA, "R4 timeout");
    step(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule